// File: doc/BRIEF.md
# Link and Duplex Resolution Monitor

This block works out, on request, whether the attached Ethernet PHY is present, whether its link is up, and which duplex and transmit-threshold setting the MAC should use. A start strobe launches one check. The check reads the PHY's basic status register and then its link-partner ability register through a simple MDIO request/response port. It then intersects the partner's abilities with the locally advertised ability word to obtain the negotiated set.

From the negotiated set the block derives a two-bit mode word: a full-duplex bit and a transmit-threshold bit. When a check yields a mode word that differs from the one held, the block stores the new word and emits a one-cycle restart pulse, so the MAC can reconfigure its transmit and receive paths. Every check ends with a one-cycle done strobe and a two-bit result code: missing PHY, no link, unchanged, or changed. The MDIO serial engine, PHY discovery and the MAC restart itself are handled elsewhere.

Top module: `link_duplex_monitor`

## Requirements
- R1: After reset, busy, done, restartPulse and mdReqValid are low, and modeFull and modeThresh are both 0.
- R2: A check reads register 1 (status) before register 5 (partner ability). mdReqValid stays high with a stable register number until mdRspValid arrives. A checkReq seen while busy is ignored, so only one check runs at a time, and no request is raised while idle.
- R3: A status response of 0xFFFF ends the check with result 3 (PHY missing). Register 5 is not read, the mode word is unchanged, and there is no restart pulse.
- R4: If status bit 2 (link) is clear, status is read a second time. If bit 2 is clear again, the check ends with result 2 (no link), without reading register 5 and with the mode word unchanged.
- R5: If the second status read shows bit 2 set, the check goes on to read register 5 as a normal check.
- R6: The negotiated set is the partner ability word ANDed with localAdv. modeThresh becomes 0 when the set contains any 100 Mb/s ability (bits 7, 8 or 9), and 1 otherwise.
- R7: modeFull becomes 1 in any of these cases: negotiated bit 8 (100BASE-TX full) is set; bit 6 (10BASE-T full) is set with no 100 Mb/s ability; or duplexLock is high. Otherwise it becomes 0.
- R8: A completed check gives result 1 (changed) with a restartPulse only when the new mode word differs from the held one. Otherwise it gives result 0 (unchanged) and no pulse.
- R9: done is a one-cycle pulse on the clock edge after the response that ends the check. result, the mode word and restartPulse are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| checkReq | input | 1 | Start strobe for one check |
| phyAddr | input | 5 | Address of the PHY to query |
| localAdv | input | 16 | Locally advertised ability word |
| duplexLock | input | 1 | Forces full duplex |
| mdReqValid | output | 1 | Register read request pending |
| mdReqPhy | output | 5 | PHY address of the request |
| mdReqReg | output | 5 | Register number of the request |
| mdRspValid | input | 1 | Read data valid (one cycle) |
| mdRspData | input | 16 | Read data |
| busy | output | 1 | A check is in progress |
| done | output | 1 | Check-complete pulse |
| result | output | 2 | 0 unchanged, 1 changed, 2 no link, 3 PHY missing |
| modeFull | output | 1 | Mode word: full duplex |
| modeThresh | output | 1 | Mode word: transmit threshold |
| restartPulse | output | 1 | Mode word changed |

## Verification
The assertions assume the MDIO side returns mdRspValid only while a request is pending, as a single-cycle pulse. They also assume that phyAddr, localAdv and duplexLock do not change while a check is in progress. The stimulus acts as the PHY side. It answers each request only after seeing it raised, waits one idle cycle first, drops the response after one cycle, and changes the configuration inputs only between checks.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam logic [ADDR_W-1:0] STAT_REG = 5'd1;
  localparam logic [ADDR_W-1:0] PART_REG = 5'd5;
  localparam int LINK_BIT = 2;
  localparam logic [DATA_W-1:0] FAST_MASK = 16'h0380;
  localparam int FD100_BIT = 8;
  localparam int FD10_BIT  = 6;

  typedef enum logic [1:0] {
    RES_SAME    = 2'd0,
    RES_CHANGED = 2'd1,
    RES_NOLINK  = 2'd2,
    RES_MISSING = 2'd3
  } result_e;

  typedef struct packed {
    logic commit;
    logic missing;
    logic noLink;
  } strobe_t;
endpackage

// File: rtl/lm_ctrl.sv
module lm_ctrl
  import lm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              checkReq,
  input  logic              mdRspValid,
  input  logic              rspAllOnes,
  input  logic              rspLinkUp,
  output logic              mdReqValid,
  output logic [ADDR_W-1:0] mdReqReg,
  output logic              busy,
  output strobe_t           strobe
);
  typedef enum logic [1:0] {S_IDLE, S_STAT1, S_STAT2, S_PART} state_e;
  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: if (checkReq) stateNext = S_STAT1;
      S_STAT1, S_STAT2: if (mdRspValid) begin
        if (rspAllOnes) begin
          strobe.commit  = 1'b1;
          strobe.missing = 1'b1;
          stateNext      = S_IDLE;
        end else if (rspLinkUp) begin
          stateNext = S_PART;
        end else if (state == S_STAT1) begin
          stateNext = S_STAT2;
        end else begin
          strobe.commit = 1'b1;
          strobe.noLink = 1'b1;
          stateNext     = S_IDLE;
        end
      end
      S_PART: if (mdRspValid) begin
        strobe.commit = 1'b1;
        stateNext     = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy       = (state != S_IDLE);
  assign mdReqValid = busy;
  assign mdReqReg   = (state == S_PART) ? PART_REG : STAT_REG;
endmodule

// File: rtl/lm_datapath.sv
module lm_datapath
  import lm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] mdRspData,
  input  logic [DATA_W-1:0] localAdv,
  input  logic              duplexLock,
  output logic              rspAllOnes,
  output logic              rspLinkUp,
  output logic              modeFull,
  output logic              modeThresh,
  output logic [1:0]        result,
  output logic              done,
  output logic              restartPulse
);
  logic [DATA_W-1:0] negSet;
  logic hasFast, newFull, newThresh, differs;

  assign rspAllOnes = &mdRspData;
  assign rspLinkUp  = mdRspData[LINK_BIT];

  assign negSet    = mdRspData & localAdv;
  assign hasFast   = |(negSet & FAST_MASK);
  assign newThresh = ~hasFast;
  assign newFull   = negSet[FD100_BIT] | (negSet[FD10_BIT] & ~hasFast) | duplexLock;
  assign differs   = (newFull != modeFull) || (newThresh != modeThresh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeFull     <= 1'b0;
      modeThresh   <= 1'b0;
      result       <= RES_SAME;
      done         <= 1'b0;
      restartPulse <= 1'b0;
    end else begin
      done         <= strobe.commit;
      restartPulse <= 1'b0;
      if (strobe.commit) begin
        if (strobe.missing)     result <= RES_MISSING;
        else if (strobe.noLink) result <= RES_NOLINK;
        else if (differs) begin
          result       <= RES_CHANGED;
          modeFull     <= newFull;
          modeThresh   <= newThresh;
          restartPulse <= 1'b1;
        end else        result <= RES_SAME;
      end
    end
  end
endmodule

// File: rtl/link_duplex_monitor.sv
module link_duplex_monitor
  import lm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              checkReq,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [DATA_W-1:0] localAdv,
  input  logic              duplexLock,
  output logic              mdReqValid,
  output logic [ADDR_W-1:0] mdReqPhy,
  output logic [ADDR_W-1:0] mdReqReg,
  input  logic              mdRspValid,
  input  logic [DATA_W-1:0] mdRspData,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic              modeFull,
  output logic              modeThresh,
  output logic              restartPulse
);
  strobe_t strobe;
  logic rspAllOnes, rspLinkUp;

  assign mdReqPhy = phyAddr;

  lm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .checkReq(checkReq), .mdRspValid(mdRspValid),
    .rspAllOnes(rspAllOnes), .rspLinkUp(rspLinkUp), .mdReqValid(mdReqValid),
    .mdReqReg(mdReqReg), .busy(busy), .strobe(strobe)
  );

  lm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mdRspData(mdRspData),
    .localAdv(localAdv), .duplexLock(duplexLock), .rspAllOnes(rspAllOnes),
    .rspLinkUp(rspLinkUp), .modeFull(modeFull), .modeThresh(modeThresh),
    .result(result), .done(done), .restartPulse(restartPulse)
  );
endmodule

// File: rtl/link_duplex_monitor_chk.sv
module link_duplex_monitor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       mdReqValid,
  input logic [4:0] mdReqReg,
  input logic       mdRspValid,
  input logic       busy,
  input logic       done,
  input logic [1:0] result,
  input logic       modeFull,
  input logic       modeThresh,
  input logic       restartPulse
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (mdReqValid && !mdRspValid) |=> (mdReqValid && $stable(mdReqReg))); // R2
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdReqValid); // R2
  AST_MISSING_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (done && result == 2'd3) |-> ($stable(modeFull) && $stable(modeThresh) && !restartPulse)); // R3
  AST_NOLINK_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (done && result == 2'd2) |-> ($stable(modeFull) && $stable(modeThresh) && !restartPulse)); // R4
  AST_RESTART_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |-> (done && result == 2'd1 && !($stable(modeFull) && $stable(modeThresh)))); // R8
  AST_SAME_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (done && result == 2'd0) |-> ($stable(modeFull) && $stable(modeThresh) && !restartPulse)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
endmodule

bind link_duplex_monitor link_duplex_monitor_chk u_chk (
  .clk(clk), .rstN(rstN), .mdReqValid(mdReqValid), .mdReqReg(mdReqReg),
  .mdRspValid(mdRspValid), .busy(busy), .done(done), .result(result),
  .modeFull(modeFull), .modeThresh(modeThresh), .restartPulse(restartPulse)
);

// File: tb/link_duplex_monitor_bench.sv
module link_duplex_monitor_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic checkReq = 1'b0;
  logic [4:0] phyAddr = 5'd3;
  logic [15:0] localAdv = 16'h01E1;
  logic duplexLock = 1'b0;
  logic mdRspValid = 1'b0;
  logic [15:0] mdRspData = 16'h0;
  logic mdReqValid, busy, done, modeFull, modeThresh, restartPulse;
  logic [4:0] mdReqPhy, mdReqReg;
  logic [1:0] result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic mFull = 1'b0, mThresh = 1'b0;

  typedef struct {
    int code;
    logic full;
    logic thresh;
    logic rst;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  link_duplex_monitor u_link_duplex_monitor (
    .clk(clk), .rstN(rstN), .checkReq(checkReq), .phyAddr(phyAddr),
    .localAdv(localAdv), .duplexLock(duplexLock), .mdReqValid(mdReqValid),
    .mdReqPhy(mdReqPhy), .mdReqReg(mdReqReg), .mdRspValid(mdRspValid),
    .mdRspData(mdRspData), .busy(busy), .done(done), .result(result),
    .modeFull(modeFull), .modeThresh(modeThresh), .restartPulse(restartPulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected outcomes when a check completes
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sb.size() == 0) check(0, "R9 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(int'(result) == e.code, {e.tag, " result"}, result, e.code);
        check(modeFull == e.full, {e.tag, " R7 full"}, modeFull, e.full);
        check(modeThresh == e.thresh, {e.tag, " R6 thresh"}, modeThresh, e.thresh);
        check(restartPulse == e.rst, {e.tag, " R8 restart"}, restartPulse, e.rst);
      end
    end
  end

  task automatic serve(input logic [4:0] expReg, input logic [15:0] data,
                       input bit poke, input string tag);
    while (!mdReqValid) @(negedge clk);
    check(mdReqReg == expReg, {tag, " R2 reg order"}, mdReqReg, expReg);
    check(mdReqPhy == phyAddr, {tag, " R2 phy"}, mdReqPhy, phyAddr);
    @(negedge clk);
    mdRspValid = 1'b1;
    mdRspData  = data;
    if (poke) checkReq = 1'b1;
    @(negedge clk);
    mdRspValid = 1'b0;
    checkReq   = 1'b0;
  endtask

  task automatic runCheck(input logic [15:0] s1, input logic [15:0] s2,
                          input logic [15:0] part, input bit poke, input string tag);
    exp_t e;
    logic [15:0] neg;
    logic nf, nt;
    bit needSecond, doPart;
    e.tag = tag;
    needSecond = (s1 != 16'hFFFF) && !s1[2];
    if (s1 == 16'hFFFF) begin
      e.code = 3; doPart = 0;
    end else if (s1[2]) doPart = 1;
    else if (s2 == 16'hFFFF) begin e.code = 3; doPart = 0; end
    else if (s2[2]) doPart = 1;
    else begin e.code = 2; doPart = 0; end
    if (doPart) begin
      neg = part & localAdv;
      nt  = ~|(neg & 16'h0380);
      nf  = neg[8] | (neg[6] & nt) | duplexLock;
      if (nf != mFull || nt != mThresh) begin
        e.code = 1; mFull = nf; mThresh = nt;
      end else e.code = 0;
    end
    e.full = mFull; e.thresh = mThresh; e.rst = (e.code == 1);
    sb.push_back(e);
    @(negedge clk) checkReq = 1'b1;
    @(negedge clk) checkReq = 1'b0;
    serve(5'd1, s1, poke, tag);
    if (needSecond) serve(5'd1, s2, 1'b0, {tag, " R4 reread"});
    if (doPart) serve(5'd5, part, 1'b0, {tag, " R5 partner"});
    check(done == 1'b1, {tag, " R9 done timing"}, done, 1);
    check(!mdReqValid && !busy, {tag, " R2 idle after check"}, mdReqValid, 0);
    @(negedge clk);
    check(!busy && !done, {tag, " R2 no extra check"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !restartPulse && !mdReqValid, "R1 idle at reset", busy, 0);
    check(!modeFull && !modeThresh, "R1 mode at reset", {modeFull, modeThresh}, 0);
    rstN = 1'b1;
    @(negedge clk);
    runCheck(16'hFFFF, 16'h0, 16'h0, 0, "R3 missing");
    runCheck(16'h0000, 16'h0000, 16'h0, 0, "R4 nolink");
    runCheck(16'h782D, 16'h0, 16'h01E1, 0, "R7 100 full");
    runCheck(16'h782D, 16'h0, 16'h01E1, 0, "R8 unchanged");
    runCheck(16'h0000, 16'h0004, 16'h0061, 0, "R5 reread link up");
    runCheck(16'h0004, 16'h0, 16'h0021, 0, "R6 10 half");
    duplexLock = 1'b1;
    runCheck(16'h0004, 16'h0, 16'h0021, 0, "R7 lock");
    duplexLock = 1'b0;
    runCheck(16'h0004, 16'h0, 16'h00C1, 0, "R6 fast present");
    localAdv = 16'h0061;
    runCheck(16'h0004, 16'h0, 16'h0181, 0, "R6 adv mask");
    runCheck(16'hFFFF, 16'h0, 16'h0, 1, "R3 missing keeps mode");
    runCheck(16'h0004, 16'h0000, 16'h0041, 1, "R2 start while busy");
    runCheck(16'h0000, 16'hFFFF, 16'h0, 0, "R3 missing on reread");
    check(sb.size() == 0, "R9 all results seen", sb.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule